// File: doc/BRIEF.md
# Timer Tick Source Selector

This block is the front end of a timer channel. It turns one of three incoming tick enables into the channel's counting tick. The three inputs are the APB clock, a slow real-time clock and an external reference, and all three arrive as single-cycle enables in one system clock domain. A shared prescaler counter divides the chosen input by a power of four. The counter itself, compare logic and interrupts belong to the next stage.

The block accepts two setting formats, chosen by `fmt_split`.

- **Combined format:** a single 3-bit code `comb_sel` chooses both the source and the division. The slow and external clocks pass straight through without the prescaler.
- **Split format:** a one-hot source field `src_sel` is paired with a 3-bit power-of-four prescale code `pre_sel`.

A separate watchdog output produces its own tick. It follows the real-time clock directly, or the external reference divided by 128, depending on `wdt_use_rtc`.

Top module: `timer_tick_select`

## Requirements
- R1: With `fmt_split`=0, `comb_sel` values 0, 1, 2 and 3 give one `tick_out` per 4, 16, 64 and 256 `apb_tick` pulses respectively, and the other inputs have no effect.
- R2: With `fmt_split`=0, `comb_sel`=4 gives one `tick_out` per `rtc_tick` and `comb_sel`=5 gives one per `ext_tick`; the unselected inputs have no effect.
- R3: With `fmt_split`=0, `comb_sel` values 6 and 7 produce no `tick_out` whatever the inputs do.
- R4: With `fmt_split`=1, `src_sel` 3'b001 selects `apb_tick`, 3'b010 selects `rtc_tick` and 3'b100 selects `ext_tick`; any other `src_sel` value produces no `tick_out`.
- R5: With `fmt_split`=1, `pre_sel` values 0 to 5 give one `tick_out` per 1, 4, 16, 64, 256 and 1024 selected input pulses; `pre_sel` values 6 and 7 produce no `tick_out`.
- R6: `tick_out` is a pulse that lasts one cycle. It is high in the cycle right after the input tick that completes a prescale period. The first output after a setting is applied comes only after a full period of input ticks.
- R7: Any change to `fmt_split`, `comb_sel`, `src_sel` or `pre_sel` clears the prescaler, and no `tick_out` is produced in the cycle after the change.
- R8: With `wdt_use_rtc`=1, `wdt_tick_out` pulses in the cycle after each `rtc_tick`, and `ext_tick` has no effect on it.
- R9: With `wdt_use_rtc`=0, `wdt_tick_out` pulses once per 128 `ext_tick` pulses, and `rtc_tick` has no effect on it. A change of `wdt_use_rtc` clears this divider.
- R10: While `rst_n` is low and in the first cycle after it rises, both outputs are low and both counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| apb_tick | input | 1 | APB clock tick enable |
| rtc_tick | input | 1 | Real-time clock tick enable |
| ext_tick | input | 1 | External reference tick enable |
| fmt_split | input | 1 | 0: combined code format, 1: split source/prescale format |
| comb_sel | input | 3 | Combined source-plus-prescale code |
| src_sel | input | 3 | One-hot source select (split format) |
| pre_sel | input | 3 | Power-of-four prescale code (split format) |
| wdt_use_rtc | input | 1 | Watchdog source: 1 real-time clock, 0 external divided by 128 |
| tick_out | output | 1 | Timer counting tick, one cycle wide |
| wdt_tick_out | output | 1 | Watchdog counting tick, one cycle wide |

## Verification
A prescaler count that is wrong or left over shows up as a wrong number of `tick_out` pulses over a window of input ticks. It can also show up as a first pulse after too few ticks, which becomes visible within one prescale period (at most 1024 selected input ticks). A wrong source decode shows up within a single input tick, either as a pulse caused by an unselected input or as a pulse missing in the following cycle. A watchdog divider fault shows up by the 128th external tick.

// File: rtl/timer_tick_select.sv
module timer_tick_select #(
  parameter int PRE_W   = 10,
  parameter int WDT_DIV = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apb_tick,
  input  logic       rtc_tick,
  input  logic       ext_tick,
  input  logic       fmt_split,
  input  logic [2:0] comb_sel,
  input  logic [2:0] src_sel,
  input  logic [2:0] pre_sel,
  input  logic       wdt_use_rtc,
  output logic       tick_out,
  output logic       wdt_tick_out
);

  localparam int WDT_W = $clog2(WDT_DIV);
  localparam int CFG_W = 10;

  logic [2:0]       src_oh;
  logic [2:0]       pow;
  logic             valid;
  logic             in_tick;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] limit;
  logic [PRE_W-1:0] cnt;
  logic [CFG_W-1:0] cfg, cfg_q;
  logic             cfg_chg;
  logic [WDT_W-1:0] wcnt;
  logic             wsel_q;

  always_comb begin
    src_oh = 3'b000;
    pow    = 3'd0;
    valid  = 1'b0;
    if (!fmt_split) begin
      unique case (comb_sel)
        3'd0, 3'd1, 3'd2, 3'd3: begin
          src_oh = 3'b001;
          pow    = comb_sel + 3'd1;
          valid  = 1'b1;
        end
        3'd4: begin src_oh = 3'b010; valid = 1'b1; end
        3'd5: begin src_oh = 3'b100; valid = 1'b1; end
        default: valid = 1'b0;
      endcase
    end else begin
      src_oh = src_sel;
      pow    = pre_sel;
      valid  = $onehot(src_sel) && (pre_sel <= 3'd5);
    end
  end

  assign in_tick = valid && |(src_oh & {ext_tick, rtc_tick, apb_tick});
  assign span    = (PRE_W+1)'(1) << {pow, 1'b0};
  assign limit   = PRE_W'(span - (PRE_W+1)'(1));
  assign cfg     = {fmt_split, comb_sel, src_sel, pre_sel};
  assign cfg_chg = (cfg != cfg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cfg_q    <= '0;
      tick_out <= 1'b0;
    end else begin
      cfg_q <= cfg;
      if (cfg_chg) begin
        cnt      <= '0;
        tick_out <= 1'b0;
      end else if (in_tick) begin
        if (cnt == limit) begin
          cnt      <= '0;
          tick_out <= 1'b1;
        end else begin
          cnt      <= cnt + 1'b1;
          tick_out <= 1'b0;
        end
      end else begin
        tick_out <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt         <= '0;
      wsel_q       <= 1'b0;
      wdt_tick_out <= 1'b0;
    end else begin
      wsel_q <= wdt_use_rtc;
      if (wdt_use_rtc != wsel_q) begin
        wcnt         <= '0;
        wdt_tick_out <= 1'b0;
      end else if (wdt_use_rtc) begin
        wdt_tick_out <= rtc_tick;
      end else if (ext_tick) begin
        if (wcnt == WDT_W'(WDT_DIV - 1)) begin
          wcnt         <= '0;
          wdt_tick_out <= 1'b1;
        end else begin
          wcnt         <= wcnt + 1'b1;
          wdt_tick_out <= 1'b0;
        end
      end else begin
        wdt_tick_out <= 1'b0;
      end
    end
  end

  assert_tick_follows_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> $past(in_tick));

  // R4 and R5 illegal settings are covered here as well
  assert_stopped_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !tick_out);

  assert_change_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (cnt == '0) && !tick_out);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> (cnt <= limit));

  assert_wdt_rtc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel_q && wdt_use_rtc && rtc_tick) |=> wdt_tick_out);

  assert_wdt_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wsel_q && !wdt_use_rtc && !ext_tick) |=> !wdt_tick_out);

endmodule

// File: tb/timer_tick_select_bench.sv
module timer_tick_select_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic apb_tick = 1'b0, rtc_tick = 1'b0, ext_tick = 1'b0;
  logic fmt_split = 1'b0;
  logic [2:0] comb_sel = 3'd7, src_sel = 3'd0, pre_sel = 3'd0;
  logic wdt_use_rtc = 1'b0;
  logic tick_out, wdt_tick_out;

  int n_chk = 0, n_fail = 0;
  int ocnt = 0, wcnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  timer_tick_select u_timer_tick_select (
    .clk(clk), .rst_n(rst_n), .apb_tick(apb_tick), .rtc_tick(rtc_tick),
    .ext_tick(ext_tick), .fmt_split(fmt_split), .comb_sel(comb_sel),
    .src_sel(src_sel), .pre_sel(pre_sel), .wdt_use_rtc(wdt_use_rtc),
    .tick_out(tick_out), .wdt_tick_out(wdt_tick_out)
  );

  always @(negedge clk) begin
    if (tick_out) ocnt++;
    if (wdt_tick_out) wcnt++;
  end

  // {fmt, comb, src, pre, mask(ext,rtc,apb), n_ticks, expected}
  localparam int NV = 22;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 3'd0, 3'd0, 3'd0, 3'b001, 12'd64,   12'd16},  // R1
    {1'b0, 3'd1, 3'd0, 3'd0, 3'b001, 12'd64,   12'd4},   // R1
    {1'b0, 3'd2, 3'd0, 3'd0, 3'b001, 12'd256,  12'd4},   // R1
    {1'b0, 3'd3, 3'd0, 3'd0, 3'b001, 12'd512,  12'd2},   // R1
    {1'b0, 3'd0, 3'd0, 3'd0, 3'b110, 12'd64,   12'd0},   // R1
    {1'b0, 3'd4, 3'd0, 3'd0, 3'b010, 12'd20,   12'd20},  // R2
    {1'b0, 3'd4, 3'd0, 3'd0, 3'b101, 12'd20,   12'd0},   // R2
    {1'b0, 3'd5, 3'd0, 3'd0, 3'b100, 12'd20,   12'd20},  // R2
    {1'b0, 3'd5, 3'd0, 3'd0, 3'b011, 12'd20,   12'd0},   // R2
    {1'b0, 3'd6, 3'd0, 3'd0, 3'b111, 12'd64,   12'd0},   // R3
    {1'b0, 3'd7, 3'd0, 3'd0, 3'b111, 12'd64,   12'd0},   // R3
    {1'b1, 3'd0, 3'd1, 3'd0, 3'b001, 12'd10,   12'd10},  // R4 R5
    {1'b1, 3'd0, 3'd2, 3'd1, 3'b010, 12'd40,   12'd10},  // R4 R5
    {1'b1, 3'd0, 3'd4, 3'd2, 3'b100, 12'd64,   12'd4},   // R4 R5
    {1'b1, 3'd0, 3'd1, 3'd3, 3'b001, 12'd128,  12'd2},   // R5
    {1'b1, 3'd0, 3'd2, 3'd4, 3'b010, 12'd512,  12'd2},   // R5
    {1'b1, 3'd0, 3'd4, 3'd5, 3'b100, 12'd2048, 12'd2},   // R5
    {1'b1, 3'd0, 3'd1, 3'd0, 3'b110, 12'd16,   12'd0},   // R4
    {1'b1, 3'd0, 3'd3, 3'd0, 3'b111, 12'd16,   12'd0},   // R4
    {1'b1, 3'd0, 3'd0, 3'd0, 3'b111, 12'd16,   12'd0},   // R4
    {1'b1, 3'd0, 3'd1, 3'd6, 3'b111, 12'd16,   12'd0},   // R5
    {1'b1, 3'd0, 3'd4, 3'd7, 3'b111, 12'd16,   12'd0}    // R5
  };

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [2:0] mask, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {ext_tick, rtc_tick, apb_tick} = mask;
      @(negedge clk);
      {ext_tick, rtc_tick, apb_tick} = 3'b000;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic setcfg(input logic f, input logic [2:0] c, input logic [2:0] s,
                        input logic [2:0] p);
    @(negedge clk);
    fmt_split = f; comb_sel = c; src_sel = s; pre_sel = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic clr;
    @(posedge clk);
    ocnt = 0;
    wcnt = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(int'(tick_out), 0, "R10 tick_out in reset");
    check(int'(wdt_tick_out), 0, "R10 wdt_tick_out in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(tick_out), 0, "R10 tick_out after reset");
    check(int'(wdt_tick_out), 0, "R10 wdt_tick_out after reset");

    wdt_use_rtc = 1'b1;
    for (int v = 0; v < NV; v++) begin
      setcfg(1'b0, 3'd7, 3'd0, 3'd0);
      setcfg(VEC[v][36], VEC[v][35:33], VEC[v][32:30], VEC[v][29:27]);
      clr();
      pulse(VEC[v][26:24], int'(VEC[v][23:12]));
      check(ocnt, int'(VEC[v][11:0]), $sformatf("R1-table row %0d (R1 R2 R3 R4 R5)", v));
    end

    // R6: single-cycle pulse, one cycle after the input tick, div 1
    setcfg(1'b1, 3'd0, 3'd1, 3'd0);
    @(negedge clk); apb_tick = 1'b1;
    @(negedge clk); apb_tick = 1'b0;
    check(int'(tick_out), 1, "R6 pulse one cycle after input");
    @(negedge clk);
    check(int'(tick_out), 0, "R6 pulse lasts one cycle");

    // R6: first output of a div-4 period comes on the 4th tick
    setcfg(1'b1, 3'd0, 3'd1, 3'd1);
    clr();
    pulse(3'b001, 3);
    check(ocnt, 0, "R6 no output before full period");
    pulse(3'b001, 1);
    check(ocnt, 1, "R6 output at full period");

    // R7: setting change clears partial count
    setcfg(1'b1, 3'd0, 3'd1, 3'd0);
    setcfg(1'b1, 3'd0, 3'd1, 3'd1);
    clr();
    pulse(3'b001, 3);
    setcfg(1'b1, 3'd0, 3'd1, 3'd2);
    setcfg(1'b1, 3'd0, 3'd1, 3'd1);
    pulse(3'b001, 3);
    check(ocnt, 0, "R7 count cleared by change");
    pulse(3'b001, 1);
    check(ocnt, 1, "R7 full period after change");

    // R8: watchdog on the real-time clock
    setcfg(1'b0, 3'd7, 3'd0, 3'd0);
    clr();
    pulse(3'b010, 10);
    check(wcnt, 10, "R8 wdt follows rtc");
    clr();
    pulse(3'b100, 50);
    check(wcnt, 0, "R8 ext ignored by wdt");

    // R9: watchdog on external / 128
    @(negedge clk); wdt_use_rtc = 1'b0;
    repeat (3) @(negedge clk);
    clr();
    pulse(3'b100, 127);
    check(wcnt, 0, "R9 no wdt tick before 128");
    pulse(3'b100, 1);
    check(wcnt, 1, "R9 wdt tick at 128");
    clr();
    pulse(3'b010, 200);
    check(wcnt, 0, "R9 rtc ignored by wdt");
    pulse(3'b100, 256);
    check(wcnt, 2, "R9 wdt ext divide");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule